// File: doc/BRIEF.md
# Layer Alpha Blend Unit

This unit composites one pixel of an upper layer over the pixel that sits beneath it. The upper pixel is either a bitmap sprite carrying a 4-bit alpha or a pixel from the 3D renderer carrying a 5-bit alpha. Both pixels arrive as 15-bit RGB. Every component is widened to 6 bits first, and all weighting happens at that precision. The unit returns an 18-bit RGB result and a flag that says whether the upper pixel is shown at all.

Each layer type gets its weights from its own alpha. A sprite gives its own pixel `alpha+1` sixteenths and the lower pixel the rest of sixteen. A 3D pixel uses thirty-seconds in the same way. When the 3D alpha is in the lower half of its range, each blended component is raised by one. A zero alpha hides the upper pixel. Blending is applied only when the pixel beneath is marked as a second target. No global effect-mode setting takes part. When the lower pixel is not a target, the widened upper pixel is passed through unchanged.

The datapath has two register stages, so a new pixel can be accepted every cycle. `out_valid` follows `in_valid` through the same stages.

Top module: `layer_blend_unit`

## Requirements
- R1: With `in_bot_target` low and the pixel visible, `out_rgb` is the upper colour widened by doubling each component. Input red is in bits [4:0], green in [9:5] and blue in [14:10]. Output red is in bits [5:0], green in [11:6] and blue in [17:12].
- R2: A sprite (`in_is_3d`=0) blended over a target gives each component as (top6*(a+1) + bot6*(15-a)) / 16, truncated, where a is the sprite alpha.
- R3: For sprites only `in_alpha[3:0]` is used. Bit 4 has no effect on the weights or on visibility.
- R4: A sprite whose alpha bits [3:0] are zero gives `out_visible`=0, and `out_rgb` is zero whenever `out_visible` is 0.
- R5: A 3D pixel (`in_is_3d`=1) blended over a target with alpha 16..31 gives each component as (top6*(a+1) + bot6*(31-a)) / 32, truncated.
- R6: A 3D pixel blended over a target with alpha 1..15 adds one to each component after the division. No increment is made when the pixel is not blended, or when the alpha is 16 or more.
- R7: A 3D pixel with alpha 0 gives `out_visible`=0, whatever `in_bot_target` is.
- R8: Each output component saturates at 63. The largest result, all components at 31 with 3D alpha 15, gives 63 in every component.
- R9: A pixel presented with `in_valid` high produces its result, with `out_valid` high, on the second rising edge after it is sampled. Otherwise `out_valid` stays low.
- R10: While `rst_n` is low and after reset, `out_valid`, `out_visible` and `out_rgb` are zero until a pixel comes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is present |
| in_top_rgb | input | 15 | Upper-layer colour, 5 bits per component |
| in_bot_rgb | input | 15 | Lower-layer colour, 5 bits per component |
| in_is_3d | input | 1 | 1 = 3D pixel, 0 = bitmap sprite |
| in_alpha | input | 5 | Upper pixel alpha (sprites use bits [3:0]) |
| in_bot_target | input | 1 | Lower pixel is enabled as a second target |
| out_valid | output | 1 | Result is present |
| out_rgb | output | 18 | Composited colour, 6 bits per component |
| out_visible | output | 1 | Upper pixel is shown |

## Verification
Every result appears two rising edges after its inputs are sampled. Stage one registers the widened colours and weights, and stage two registers the mixed colour. The bench drives inputs on the falling edge, waits two rising edges and samples on the next falling edge. No sample is taken while a value is still passing through a register. The valid test samples one, two and three edges after a single-cycle pulse, so that an extra or a missing stage is caught.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic {
        LAYER_SPRITE = 1'b0,
        LAYER_3D     = 1'b1
    } layer_e;

    localparam int unsigned NCH = 3;

endpackage

// File: rtl/lbc_expand.sv
module lbc_expand #(
    parameter int unsigned CW  = 5,
    parameter int unsigned NCH = 3,
    localparam int unsigned XW = CW + 1
) (
    input  logic [NCH*CW-1:0] narrow_i,
    output logic [NCH*XW-1:0] wide_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // widen by doubling: shift left one, low bit zero
        assign wide_o[c*XW +: XW] = {narrow_i[c*CW +: CW], 1'b0};
    end

endmodule

// File: rtl/lbc_weight.sv
module lbc_weight #(
    parameter int unsigned AW     = 5,
    parameter int unsigned SPR_AW = 4,
    localparam int unsigned WW    = AW + 1
) (
    input  logic          is_3d_i,
    input  logic [AW-1:0] alpha_i,
    output logic [WW-1:0] eva_o,
    output logic [WW-1:0] evb_o,
    output logic          low_alpha_o,
    output logic          shown_o
);

    localparam logic [WW-1:0] SPR_SCALE = WW'(1 << SPR_AW);
    localparam logic [WW-1:0] TD_SCALE  = WW'(1 << AW);

    logic [SPR_AW-1:0] spr_alpha;

    always_comb begin
        spr_alpha = alpha_i[SPR_AW-1:0];
        if (is_3d_i) begin
            eva_o       = WW'(alpha_i) + WW'(1);
            evb_o       = TD_SCALE - eva_o;
            shown_o     = (alpha_i != '0);
            low_alpha_o = ~alpha_i[AW-1];
        end else begin
            eva_o       = WW'(spr_alpha) + WW'(1);
            evb_o       = SPR_SCALE - eva_o;
            shown_o     = (spr_alpha != '0);
            low_alpha_o = 1'b0;
        end
    end

endmodule

// File: rtl/lbc_mix_chan.sv
module lbc_mix_chan #(
    parameter int unsigned XW     = 6,
    parameter int unsigned AW     = 5,
    parameter int unsigned SPR_AW = 4,
    localparam int unsigned WW    = AW + 1,
    localparam int unsigned SW    = XW + WW + 1
) (
    input  logic [XW-1:0] top_i,
    input  logic [XW-1:0] bot_i,
    input  logic [WW-1:0] eva_i,
    input  logic [WW-1:0] evb_i,
    input  logic          is_3d_i,
    input  logic          bump_i,
    input  logic          blend_i,
    output logic [XW-1:0] res_o
);

    localparam logic [SW-1:0] MAXV = SW'((1 << XW) - 1);

    logic [SW-1:0] sum;
    logic [SW-1:0] quot;
    logic [SW-1:0] adj;

    always_comb begin
        sum  = SW'(top_i) * SW'(eva_i) + SW'(bot_i) * SW'(evb_i);
        quot = is_3d_i ? (sum >> AW) : (sum >> SPR_AW);
        adj  = quot + SW'(bump_i);
        if (!blend_i) begin
            res_o = top_i;
        end else if (adj > MAXV) begin
            res_o = XW'(MAXV);
        end else begin
            res_o = adj[XW-1:0];
        end
    end

endmodule

// File: rtl/layer_blend_unit.sv
module layer_blend_unit #(
    parameter int unsigned CW     = 5,
    parameter int unsigned AW     = 5,
    parameter int unsigned SPR_AW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3*CW-1:0]      in_top_rgb,
    input  logic [3*CW-1:0]      in_bot_rgb,
    input  logic                 in_is_3d,
    input  logic [AW-1:0]        in_alpha,
    input  logic                 in_bot_target,
    output logic                 out_valid,
    output logic [3*(CW+1)-1:0]  out_rgb,
    output logic                 out_visible
);

    import lbc_pkg::*;

    localparam int unsigned XW = CW + 1;
    localparam int unsigned WW = AW + 1;
    localparam int unsigned PW = NCH * XW;

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] top;
        logic [PW-1:0] bot;
        logic [WW-1:0] eva;
        logic [WW-1:0] evb;
        logic          is_3d;
        logic          bump;
        logic          blend;
        logic          shown;
    } stage1_t;

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] rgb;
        logic          shown;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic [PW-1:0] top_wide;
    logic [PW-1:0] bot_wide;
    logic [WW-1:0] eva;
    logic [WW-1:0] evb;
    logic          low_alpha;
    logic          shown;
    logic [PW-1:0] mixed;
    layer_e        kind;

    assign kind = layer_e'(in_is_3d);

    lbc_expand #(.CW(CW), .NCH(NCH)) u_exp_top (
        .narrow_i (in_top_rgb),
        .wide_o   (top_wide)
    );

    lbc_expand #(.CW(CW), .NCH(NCH)) u_exp_bot (
        .narrow_i (in_bot_rgb),
        .wide_o   (bot_wide)
    );

    lbc_weight #(.AW(AW), .SPR_AW(SPR_AW)) u_weight (
        .is_3d_i     (kind == LAYER_3D),
        .alpha_i     (in_alpha),
        .eva_o       (eva),
        .evb_o       (evb),
        .low_alpha_o (low_alpha),
        .shown_o     (shown)
    );

    // stage 1: widened colours and weights
    always_comb begin
        s1_d.valid = in_valid;
        s1_d.top   = top_wide;
        s1_d.bot   = bot_wide;
        s1_d.eva   = eva;
        s1_d.evb   = evb;
        s1_d.is_3d = (kind == LAYER_3D);
        s1_d.blend = in_bot_target;
        s1_d.bump  = in_bot_target & low_alpha;
        s1_d.shown = shown;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_mix
        lbc_mix_chan #(.XW(XW), .AW(AW), .SPR_AW(SPR_AW)) u_chan (
            .top_i   (s1_q.top[c*XW +: XW]),
            .bot_i   (s1_q.bot[c*XW +: XW]),
            .eva_i   (s1_q.eva),
            .evb_i   (s1_q.evb),
            .is_3d_i (s1_q.is_3d),
            .bump_i  (s1_q.bump),
            .blend_i (s1_q.blend),
            .res_o   (mixed[c*XW +: XW])
        );
    end

    // stage 2: mixed colour, zeroed when hidden
    always_comb begin
        s2_d.valid = s1_q.valid;
        s2_d.shown = s1_q.shown;
        s2_d.rgb   = s1_q.shown ? mixed : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid   = s2_q.valid;
    assign out_rgb     = s2_q.rgb;
    assign out_visible = s2_q.shown;

    function automatic logic [PW-1:0] widen_ref(input logic [3*CW-1:0] v);
        logic [PW-1:0] w;
        for (int c = 0; c < NCH; c++) begin
            w[c*XW +: XW] = {v[c*CW +: CW], 1'b0};
        end
        return w;
    endfunction

    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r4_sprite_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_is_3d && in_alpha[SPR_AW-1:0] == '0) |-> ##2 !out_visible);

    a_r7_3d_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (in_is_3d && in_alpha == '0) |-> ##2 !out_visible);

    a_r4_hidden_black: assert property (@(posedge clk) disable iff (!rst_n)
        !out_visible |-> (out_rgb == '0));

    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_bot_target && (in_is_3d ? (in_alpha != '0) : (in_alpha[SPR_AW-1:0] != '0)))
        |-> ##2 (out_rgb == widen_ref($past(in_top_rgb, 2))));

endmodule

// File: tb/sim_layer_blend_unit.sv
module sim_layer_blend_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [14:0] in_top_rgb;
    logic [14:0] in_bot_rgb;
    logic        in_is_3d;
    logic [4:0]  in_alpha;
    logic        in_bot_target;
    logic        out_valid;
    logic [17:0] out_rgb;
    logic        out_visible;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    layer_blend_unit u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_top_rgb    (in_top_rgb),
        .in_bot_rgb    (in_bot_rgb),
        .in_is_3d      (in_is_3d),
        .in_alpha      (in_alpha),
        .in_bot_target (in_bot_target),
        .out_valid     (out_valid),
        .out_rgb       (out_rgb),
        .out_visible   (out_visible)
    );

    // {top b,g,r | bot b,g,r | is_3d | alpha | target | exp visible | exp B,G,R}
    localparam int NV = 13;
    localparam logic [55:0] VEC [NV] = '{
        {5'd31,5'd2,5'd1,   15'd0,             1'b0, 5'd5,  1'b0, 1'b1, 6'd62,6'd4,6'd2},   // R1
        {5'd10,5'd0,5'd31,  5'd20,5'd31,5'd0,  1'b0, 5'd7,  1'b1, 1'b1, 6'd30,6'd31,6'd31}, // R2
        {5'd0,5'd7,5'd5,    5'd3,5'd0,5'd4,    1'b0, 5'd2,  1'b1, 1'b1, 6'd4,6'd2,6'd8},    // R2 truncation
        {5'd0,5'd0,5'd16,   15'd0,             1'b0, 5'd19, 1'b1, 1'b1, 6'd0,6'd0,6'd8},    // R3
        {5'd1,5'd1,5'd1,    5'd2,5'd2,5'd2,    1'b0, 5'd16, 1'b1, 1'b0, 18'd0},             // R4
        {5'd0,5'd31,5'd10,  5'd31,5'd0,5'd20,  1'b1, 5'd20, 1'b1, 1'b1, 6'd21,6'd40,6'd26}, // R5
        {5'd8,5'd0,5'd31,   5'd8,5'd16,5'd0,   1'b1, 5'd3,  1'b1, 1'b1, 6'd17,6'd29,6'd8},  // R6
        {5'd31,5'd31,5'd31, 5'd31,5'd31,5'd31, 1'b1, 5'd15, 1'b1, 1'b1, 6'd63,6'd63,6'd63}, // R8
        {5'd5,5'd5,5'd5,    5'd5,5'd5,5'd5,    1'b1, 5'd0,  1'b1, 1'b0, 18'd0},             // R7
        {5'd1,5'd1,5'd1,    5'd9,5'd9,5'd9,    1'b1, 5'd3,  1'b0, 1'b1, 6'd2,6'd2,6'd2},    // R6 no target
        {5'd5,5'd4,5'd3,    5'd31,5'd31,5'd31, 1'b1, 5'd31, 1'b1, 1'b1, 6'd10,6'd8,6'd6},   // R5 full alpha
        {5'd7,5'd7,5'd7,    15'd0,             1'b0, 5'd0,  1'b0, 1'b0, 18'd0},             // R4 no target
        {5'd0,5'd0,5'd0,    5'd1,5'd1,5'd1,    1'b1, 5'd16, 1'b1, 1'b1, 18'd0}              // R6 alpha 16
    };

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R1";
            1, 2:    return "R2";
            3:       return "R3";
            4, 11:   return "R4";
            5, 10:   return "R5";
            6, 9, 12: return "R6";
            7:       return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid      = 1'b0;
        in_top_rgb    = '0;
        in_bot_rgb    = '0;
        in_is_3d      = 1'b0;
        in_alpha      = '0;
        in_bot_target = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs held at zero during reset
        check("R10 valid in reset", 32'(out_valid), 32'd0);
        check("R10 rgb in reset", 32'(out_rgb), 32'd0);
        rst_n = 1'b1;
        idle_inputs();
        @(posedge clk);
        @(negedge clk);
        check("R10 visible after reset", 32'(out_visible), 32'd0);
        check("R10 valid after reset", 32'(out_valid), 32'd0);

        // table walk: result due two edges after sampling
        for (int i = 0; i < NV; i++) begin
            in_valid      = 1'b1;
            in_top_rgb    = VEC[i][55:41];
            in_bot_rgb    = VEC[i][40:26];
            in_is_3d      = VEC[i][25];
            in_alpha      = VEC[i][24:20];
            in_bot_target = VEC[i][19];
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check({tag_of(i), " visible"}, 32'(out_visible), 32'(VEC[i][18]));
            check({tag_of(i), " rgb"}, 32'(out_rgb), 32'(VEC[i][17:0]));
            check("R9 valid in stream", 32'(out_valid), 32'd1);
        end

        // R9: single-cycle pulse timing
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        in_valid   = 1'b1;
        in_top_rgb = {5'd3, 5'd2, 5'd1};
        in_alpha   = 5'd9;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 valid after one edge", 32'(out_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R9 valid after two edges", 32'(out_valid), 32'd1);
        check("R9 rgb after two edges", 32'(out_rgb), {14'd0, 6'd6, 6'd4, 6'd2});
        @(posedge clk);
        @(negedge clk);
        check("R9 valid after three edges", 32'(out_valid), 32'd0);

        // R10: reset in the middle of a stream clears outputs
        in_valid = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 valid after mid reset", 32'(out_valid), 32'd0);
        check("R10 visible after mid reset", 32'(out_visible), 32'd0);
        check("R10 rgb after mid reset", 32'(out_rgb), 32'd0);
        rst_n = 1'b1;
        idle_inputs();
        repeat (2) @(posedge clk);

        finish_run();
    end

endmodule